// File: doc/BRIEF.md
# Timer Output Compare Channel

An 8-bit timer/counter with one output compare channel that drives a single waveform output. The counter advances once per timer clock enable pulse (`tick`), which comes from an external prescaler. The counter value is compared against a programmable compare value. On a match the channel sets a sticky match flag and applies a set, clear or toggle action to the waveform output. In the clear-on-match waveform mode the counter also restarts from zero.

Software uses a small register port with four addresses. Address 0 is control, address 1 is the counter, address 2 is the compare value and address 3 is status. The port has one write strobe, and the read data follows the address combinationally.

The control register holds the waveform mode in bits [1:0], the output action in bits [3:2] and a self-clearing force strobe in bit 7. The force strobe applies the output action without a real match.

A compare-suppression state machine has two states: `BLK_ARMED` and `BLK_HOLD`. A counter write moves it from `BLK_ARMED` to `BLK_HOLD`. Further counter writes keep it in `BLK_HOLD`. The first timer tick that arrives without a counter write returns it from `BLK_HOLD` to `BLK_ARMED`, and no match is allowed on that tick. The timer may be stopped with no ticks; the machine stays in `BLK_HOLD` for as long as that lasts.

Top module: `timer_oc`

## Requirements
- R1: After reset, the counter, compare value, control register, match flag and waveform output are all zero.
- R2: The counter advances by one only on a cycle with `tick` high, and otherwise holds its value. A write to address 1 loads the counter. That write takes priority over a tick in the same cycle.
- R3: Control bits [3:2] select the action on a compare match:
  - 00 leaves the output unchanged.
  - 01 toggles it.
  - 10 clears it.
  - 11 sets it.
  - The action applies only in the non-PWM waveform modes. In control bits [1:0], 00 is normal and 10 is clear-on-match; 01 and 11 are PWM encodings, which apply no action.
- R4: A tick on which the counter equals the compare value sets the match flag (status bit 0) at that clock edge.
- R5: Writing a one to status bit 0 clears the match flag. If a match occurs in the same cycle, the set wins.
- R6: In normal mode the counter wraps from 255 to 0. In clear-on-match mode, a tick that produces a match loads the counter with 0.
- R7: Changing the waveform mode does not change the current waveform output value.
- R8: After any counter write, the first later tick can produce no match, even if idle cycles with no tick pass in between. Ticks after that one match normally.
- R9: Writing the counter with the compare value loses that match: no flag, no output action, and in clear-on-match mode the counter steps past the compare value instead of restarting.
- R10: Writing control with bit 7 set applies the action field carried by that same write to the output at once. It leaves the match flag and the counter untouched. Control bit 7 always reads back as zero.
- R11: A forced compare with action field 00 leaves the waveform output unchanged.
- R12: A forced compare is ignored when the same control write selects a PWM waveform mode.
- R13: A new action field takes effect on the very next match, with no buffering against the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read: 0 control, 1 counter, 2 compare, 3 status |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for `addr` |
| wave_out | output | 1 | Waveform output |
| match_flag | output | 1 | Sticky compare match flag |

## Verification
The suppression state is the internal state most likely to go wrong. If it is stuck in `BLK_HOLD`, the output and flag stop responding to matches at the first compare after a counter write. If it leaves `BLK_HOLD` too early, a counter written equal to the compare value shows a flag and an output change at the very next tick, where none should appear. A wrong counter next-state shows up within one tick as a wrong read of address 1. A wrong action decode shows up on `wave_out` at the matching tick or immediately on a force write.

// File: rtl/timer_oc_pkg.sv
package timer_oc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef enum logic [1:0] {
        WM_NORMAL    = 2'b00,
        WM_PWM_A     = 2'b01,
        WM_CLR_MATCH = 2'b10,
        WM_PWM_B     = 2'b11
    } wave_mode_e;

    typedef enum logic {
        BLK_ARMED = 1'b0,
        BLK_HOLD  = 1'b1
    } blk_state_e;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_CMP = 2'd2;
    localparam logic [1:0] ADDR_STS = 2'd3;

    localparam int CTL_FORCE_BIT = 7;

    function automatic logic oc_apply(input oc_act_e act, input logic cur);
        logic res;
        unique case (act)
            ACT_NONE:   res = cur;
            ACT_TOGGLE: res = ~cur;
            ACT_CLEAR:  res = 1'b0;
            ACT_SET:    res = 1'b1;
            default:    res = cur;
        endcase
        return res;
    endfunction

    function automatic logic is_pwm(input wave_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/timer_oc_regs.sv
module timer_oc_regs
    import timer_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         match_evt,
    output wave_mode_e   mode,
    output oc_act_e      act,
    output logic [W-1:0] cmp,
    output logic         flag,
    output logic         cnt_wr,
    output logic         force_pulse,
    output oc_act_e      force_act,
    output logic [W-1:0] rd_data
);

    localparam int PAD_W = W - 4;

    logic ctl_wr, cmp_wr, sts_wr;

    always_comb begin
        ctl_wr      = wr_en && (addr == ADDR_CTL);
        cnt_wr      = wr_en && (addr == ADDR_CNT);
        cmp_wr      = wr_en && (addr == ADDR_CMP);
        sts_wr      = wr_en && (addr == ADDR_STS);
        force_act   = oc_act_e'(wr_data[3:2]);
        force_pulse = ctl_wr && wr_data[CTL_FORCE_BIT]
                      && !is_pwm(wave_mode_e'(wr_data[1:0]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= WM_NORMAL;
            act  <= ACT_NONE;
            cmp  <= '0;
        end else begin
            if (ctl_wr) begin
                mode <= wave_mode_e'(wr_data[1:0]);
                act  <= oc_act_e'(wr_data[3:2]);
            end
            if (cmp_wr) begin
                cmp <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match_evt) begin
            flag <= 1'b1;
        end else if (sts_wr && wr_data[0]) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTL: rd_data = {{PAD_W{1'b0}}, act, mode};
            ADDR_CNT: rd_data = cnt;
            ADDR_CMP: rd_data = cmp;
            ADDR_STS: rd_data = {{(W-1){1'b0}}, flag};
            default:  rd_data = '0;
        endcase
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag);

    p_force_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_pulse && !match_evt && !flag) |=> !flag);

    p_ctl_force_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CTL) |-> !rd_data[CTL_FORCE_BIT]);

endmodule

// File: rtl/timer_oc_counter.sv
module timer_oc_counter
    import timer_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] cmp,
    input  wave_mode_e   mode,
    output logic [W-1:0] cnt,
    output logic         match_evt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    blk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_ARMED: if (cnt_wr) state_d = BLK_HOLD;
            BLK_HOLD: begin
                if (cnt_wr)    state_d = BLK_HOLD;
                else if (tick) state_d = BLK_ARMED;
            end
            default: state_d = BLK_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BLK_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        match_evt = 1'b0;
        unique case (state_q)
            BLK_ARMED: match_evt = tick && !cnt_wr && (cnt == cmp);
            BLK_HOLD:  match_evt = 1'b0;
            default:   match_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
        end else if (tick) begin
            if (match_evt && (mode == WM_CLR_MATCH)) cnt <= '0;
            else                                     cnt <= cnt + 1'b1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));

    p_ctc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mode == WM_CLR_MATCH) |=> (cnt == '0));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == CNT_MAX) |=> (cnt == '0));

    p_block_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_wr) && tick && !cnt_wr) |-> !match_evt);

endmodule

// File: rtl/timer_oc_wave.sv
module timer_oc_wave
    import timer_oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_evt,
    input  wave_mode_e mode,
    input  oc_act_e    act,
    input  logic       force_pulse,
    input  oc_act_e    force_act,
    output logic       wave_out
);

    logic wave_d;

    always_comb begin
        wave_d = wave_out;
        if (match_evt && !is_pwm(mode)) begin
            wave_d = oc_apply(act, wave_out);
        end else if (force_pulse) begin
            wave_d = oc_apply(force_act, wave_out);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wave_out <= 1'b0;
        else        wave_out <= wave_d;
    end

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_evt && !force_pulse) |=> $stable(wave_out));

    p_force_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (force_pulse && !match_evt && force_act == ACT_NONE) |=> $stable(wave_out));

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !is_pwm(mode) && act == ACT_SET) |=> wave_out);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !is_pwm(mode) && act == ACT_CLEAR) |=> !wave_out);

endmodule

// File: rtl/timer_oc.sv
module timer_oc
    import timer_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         wave_out,
    output logic         match_flag
);

    wave_mode_e   mode;
    oc_act_e      act;
    oc_act_e      force_act;
    logic [W-1:0] cmp;
    logic [W-1:0] cnt;
    logic         cnt_wr;
    logic         force_pulse;
    logic         match_evt;

    timer_oc_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .cnt         (cnt),
        .match_evt   (match_evt),
        .mode        (mode),
        .act         (act),
        .cmp         (cmp),
        .flag        (match_flag),
        .cnt_wr      (cnt_wr),
        .force_pulse (force_pulse),
        .force_act   (force_act),
        .rd_data     (rd_data)
    );

    timer_oc_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .cmp       (cmp),
        .mode      (mode),
        .cnt       (cnt),
        .match_evt (match_evt)
    );

    timer_oc_wave u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .match_evt   (match_evt),
        .mode        (mode),
        .act         (act),
        .force_pulse (force_pulse),
        .force_act   (force_act),
        .wave_out    (wave_out)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!wave_out && !match_flag));

endmodule

// File: tb/timer_oc_tb_top.sv
module timer_oc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 25;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_T = 2'd1;
    localparam logic [1:0] OP_I = 2'd2;

    // Row fields: op, addr, data, expected count, flag, wave, requirement number.
    localparam logic [25:0] VEC [NVEC] = '{
        {OP_W, 2'd2, 8'd5,    8'd0,   1'b0, 1'b0, 4'd1},  // R1 compare load
        {OP_W, 2'd0, 8'h04,   8'd0,   1'b0, 1'b0, 4'd3},  // R3 toggle, normal
        {OP_T, 2'd0, 8'd5,    8'd5,   1'b0, 1'b0, 4'd2},  // R2 five ticks
        {OP_T, 2'd0, 8'd1,    8'd6,   1'b1, 1'b1, 4'd4},  // R4 match toggles
        {OP_W, 2'd3, 8'h01,   8'd6,   1'b0, 1'b1, 4'd5},  // R5 clear flag
        {OP_W, 2'd0, 8'h0A,   8'd6,   1'b0, 1'b1, 4'd7},  // R7 mode change keeps wave
        {OP_W, 2'd1, 8'd3,    8'd3,   1'b0, 1'b1, 4'd2},  // R2 counter load
        {OP_T, 2'd0, 8'd1,    8'd4,   1'b0, 1'b1, 4'd8},  // R8 suppressed tick
        {OP_T, 2'd0, 8'd1,    8'd5,   1'b0, 1'b1, 4'd2},
        {OP_T, 2'd0, 8'd1,    8'd0,   1'b1, 1'b0, 4'd6},  // R6 restart, R3 clear
        {OP_W, 2'd3, 8'h01,   8'd0,   1'b0, 1'b0, 4'd5},
        {OP_W, 2'd0, 8'h0E,   8'd0,   1'b0, 1'b0, 4'd13}, // R13 set action now
        {OP_W, 2'd1, 8'd5,    8'd5,   1'b0, 1'b0, 4'd9},  // R9 write equals compare
        {OP_I, 2'd0, 8'd3,    8'd5,   1'b0, 1'b0, 4'd8},  // R8 stopped timer
        {OP_T, 2'd0, 8'd1,    8'd6,   1'b0, 1'b0, 4'd9},  // R9 match lost
        {OP_W, 2'd1, 8'd4,    8'd4,   1'b0, 1'b0, 4'd8},
        {OP_T, 2'd0, 8'd1,    8'd5,   1'b0, 1'b0, 4'd8},
        {OP_T, 2'd0, 8'd1,    8'd0,   1'b1, 1'b1, 4'd13}, // R13 set on match
        {OP_W, 2'd3, 8'h01,   8'd0,   1'b0, 1'b1, 4'd5},
        {OP_W, 2'd0, 8'h84,   8'd0,   1'b0, 1'b0, 4'd10}, // R10 force toggle
        {OP_W, 2'd0, 8'h80,   8'd0,   1'b0, 1'b0, 4'd11}, // R11 force none
        {OP_W, 2'd0, 8'h85,   8'd0,   1'b0, 1'b0, 4'd12}, // R12 force in PWM
        {OP_W, 2'd0, 8'h8C,   8'd0,   1'b0, 1'b1, 4'd10}, // R10 force set
        {OP_W, 2'd1, 8'd255,  8'd255, 1'b0, 1'b1, 4'd2},
        {OP_T, 2'd0, 8'd1,    8'd0,   1'b0, 1'b1, 4'd6}   // R6 wrap
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       wave_out;
    logic       match_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    timer_oc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .wave_out   (wave_out),
        .match_flag (match_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic check_state(input int req, input int ecnt, input int eflag, input int ewave);
        logic [7:0] v;
        read_reg(2'd1, v);
        check(req, "count", int'(v), ecnt);
        check(req, "flag", int'(match_flag), eflag);
        check(req, "wave", int'(wave_out), ewave);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        failures++;
        $display("FAIL R0 watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            read_reg(a[1:0], v);
            check(1, "reset register", int'(v), 0);
        end
        check(1, "reset wave", int'(wave_out), 0);
        check(1, "reset flag", int'(match_flag), 0);

        for (int k = 0; k < NVEC; k++) begin
            logic [25:0] e;
            e = VEC[k];
            unique case (e[25:24])
                OP_W: reg_write(e[23:22], e[21:14]);
                OP_T: ticks(int'(e[21:14]));
                default: repeat (int'(e[21:14])) @(negedge clk);
            endcase
            check_state(int'(e[3:0]), int'(e[13:6]), int'(e[5]), int'(e[4]));
        end

        // R10: force strobe reads back as zero, fields kept
        read_reg(2'd0, v);
        check(10, "control readback", int'(v), 8'h0C);

        // R2: counter write wins over a coincident tick
        reg_write(2'd2, 8'h42);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd1; wr_data = 8'h40; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check_state(2, 8'h40, 0, 1);
        ticks(2);
        check_state(2, 8'h42, 0, 1);

        // R5: match and flag clear in the same cycle, set wins
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wr_data = 8'h01; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(5, "flag set wins over clear", int'(match_flag), 1);
        reg_write(2'd3, 8'h01);
        check(5, "flag cleared", int'(match_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule